// File: doc/BRIEF.md
# GPIO Interrupt Summary and End-of-Interrupt Control

This block sits between the per-pin trigger logic of a GPIO bank and the host interrupt controller. It folds the pending flags of the bank's pins into one summary bit per group of four pins. Software reads this summary as two 32-bit words to find which groups need service. The block drives a single host interrupt line. Once raised, the line stays high until software writes an end-of-interrupt command.

A control word holds a settle-window length, a window enable and the end-of-interrupt command. When the window is enabled, any write to any pin's debounce setup opens a global quiet period that lasts the programmed number of clocks. During that period no group can raise status, and every pin's interrupt-enable bit reads back as zero. Software polls that readback to learn when the debounce change has settled.

Top module: `gpio_irq_summary`

## Requirements
- R1: Summary bit k is registered once per clock as the OR of `pend_i` bits 4k to 4k+3. It becomes visible one clock after the pending inputs that produce it.
- R2: Reads at address 0 return summary bits 31..0. Reads at address 1 return summary bits 45..32 in bits 13..0, with zeros above. Reads at address 3 return zero. Writes to addresses 0, 1 and 3 change nothing.
- R3: The control word sits at address 2 and has three fields: bits 11..0 hold the window length, bit 16 holds the window enable, and bit 31 is the end-of-interrupt command. A read returns length and enable, and bit 31 always reads as zero.
- R4: The host line rises one clock after the summary becomes nonzero. It then stays high, even after the summary clears, until an end-of-interrupt write.
- R5: An end-of-interrupt write drives the line low on the next clock. This holds even if the summary is nonzero in the same cycle. If the summary is still nonzero, the line rises again one clock later.
- R6: A `db_wr_i` strobe, while the enable is set and the length L is nonzero, opens a quiet window that covers the L clocks after the strobe. With L equal to zero, or with the enable clear, the strobe opens no window.
- R7: During the window the summary loads zero, and `int_en_rd_o` reads all zeros. Outside the window, `int_en_rd_o` equals `int_en_i`.
- R8: A `db_wr_i` strobe that arrives inside a window restarts the count at the full length.
- R9: When a control-word write and a `db_wr_i` strobe fall in the same cycle, the window uses the length and enable held before that write.
- R10: After reset, the summary, the length, the enable and the host line are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | 184 | Pending flag from each pin's trigger logic |
| int_en_i | input | 184 | Configured interrupt-enable bit of each pin |
| db_wr_i | input | 1 | Strobe: software wrote some pin's debounce setup |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0 low status, 1 high status, 2 control) |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| int_en_rd_o | output | 184 | Interrupt-enable readback, forced to zero inside the quiet window |
| host_irq_o | output | 1 | Interrupt line to the host |

## Verification
Two pairs of actions can land in the same cycle. The first pair is an end-of-interrupt write and a nonzero summary. The bench holds a pin pending while it issues the command, then expects the line to go low for exactly one clock and rise again. The second pair is a control-word write and a debounce strobe. The bench issues both together and expects the window to last the old length, not the new one. Random traffic mixes both collisions with window restarts, with writes to the read-only words, and with pending bits in the top group. Every cycle is judged against a cycle-level reference model.

// File: rtl/gis_pkg.sv
package gis_pkg;
  typedef enum logic [1:0] {
    ADDR_STAT_LO = 2'd0,
    ADDR_STAT_HI = 2'd1,
    ADDR_CTRL    = 2'd2,
    ADDR_RSVD    = 2'd3
  } gis_addr_e;

  localparam int CTRL_EN_BIT  = 16;
  localparam int CTRL_EOI_BIT = 31;
endpackage

// File: rtl/gis_group_or.sv
module gis_group_or #(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE
) (
  input  logic [NUM_PINS-1:0] pend_i,
  output logic [NUM_GRP-1:0]  grp_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_o[g] = |pend_i[g*GRP_SIZE +: GRP_SIZE];
  end
endmodule

// File: rtl/gis_quiet_timer.sv
module gis_quiet_timer #(
  parameter int LEN_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             quiet_o
);
  logic [LEN_W-1:0] cnt_q;

  // a new start reloads the full length, also mid-window
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (start_i)       cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign quiet_o = (cnt_q != '0);
endmodule

// File: rtl/gis_irq_ctrl.sv
module gis_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sum_any_i,
  input  logic eoi_i,
  output logic irq_o
);
  logic irq_q;

  // eoi wins over a coincident summary; line re-rises next clock
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_q <= 1'b0;
    else if (eoi_i)     irq_q <= 1'b0;
    else if (sum_any_i) irq_q <= 1'b1;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary
  import gis_pkg::*;
#(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  parameter int LEN_W    = 12,
  parameter int DATA_W   = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pend_i,
  input  logic [NUM_PINS-1:0] int_en_i,
  input  logic                db_wr_i,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_addr_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  output logic [NUM_PINS-1:0] int_en_rd_o,
  output logic                host_irq_o
);
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE;
  localparam int STAT_W  = 2 * DATA_W;

  logic [NUM_GRP-1:0] grp;
  logic [NUM_GRP-1:0] sum_q;
  logic [STAT_W-1:0]  sum_ext;
  logic [LEN_W-1:0]   len_q;
  logic               en_q;
  logic               quiet;
  logic               ctrl_wr;
  logic               eoi;

  assign ctrl_wr = reg_wr_i && (reg_addr_i == ADDR_CTRL);
  assign eoi     = ctrl_wr && reg_wdata_i[CTRL_EOI_BIT];

  gis_group_or #(.NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE)) u_grp (
    .pend_i (pend_i),
    .grp_o  (grp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      en_q  <= 1'b0;
    end else if (ctrl_wr) begin
      len_q <= reg_wdata_i[LEN_W-1:0];
      en_q  <= reg_wdata_i[CTRL_EN_BIT];
    end
  end

  // timer sees the pre-write settings when a ctrl write coincides
  gis_quiet_timer #(.LEN_W(LEN_W)) u_quiet (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (db_wr_i && en_q),
    .len_i   (len_q),
    .quiet_o (quiet)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (quiet) sum_q <= '0;
    else            sum_q <= grp;
  end

  gis_irq_ctrl u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sum_any_i (|sum_q),
    .eoi_i     (eoi),
    .irq_o     (host_irq_o)
  );

  assign sum_ext     = {{(STAT_W-NUM_GRP){1'b0}}, sum_q};
  assign int_en_rd_o = quiet ? '0 : int_en_i;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_STAT_LO: reg_rdata_o = sum_ext[DATA_W-1:0];
      ADDR_STAT_HI: reg_rdata_o = sum_ext[STAT_W-1:DATA_W];
      ADDR_CTRL: begin
        reg_rdata_o[LEN_W-1:0]   = len_q;
        reg_rdata_o[CTRL_EN_BIT] = en_q;
      end
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_summary_chk.sv
module gpio_irq_summary_chk #(
  parameter int NUM_PINS = 184,
  parameter int GRP_SIZE = 4,
  parameter int LEN_W    = 12,
  parameter int DATA_W   = 32,
  localparam int NUM_GRP = NUM_PINS / GRP_SIZE
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                db_wr_i,
  input logic                reg_wr_i,
  input logic [1:0]          reg_addr_i,
  input logic [DATA_W-1:0]   reg_wdata_i,
  input logic [DATA_W-1:0]   reg_rdata_o,
  input logic [NUM_PINS-1:0] int_en_rd_o,
  input logic                host_irq_o,
  input logic                quiet,
  input logic                en_q,
  input logic [LEN_W-1:0]    len_q,
  input logic [NUM_GRP-1:0]  sum_q
);
  logic eoi_w;
  assign eoi_w = reg_wr_i && (reg_addr_i == 2'd2) && reg_wdata_i[31];

  a_r5_eoi_drops_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_w |=> !host_irq_o);

  a_r4_line_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_irq_o && !eoi_w) |=> host_irq_o);

  a_r4_rise_needs_summary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!host_irq_o && (sum_q == '0)) |=> !host_irq_o);

  a_r7_enable_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |-> (int_en_rd_o == '0));

  a_r7_summary_held_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    quiet |=> (sum_q == '0));

  a_r6_window_opens: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (db_wr_i && en_q && (len_q != '0)) |=> quiet);

  a_r6_no_spurious_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!quiet && !(db_wr_i && en_q)) |=> !quiet);

  a_r3_eoi_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd2) |-> !reg_rdata_o[31]);

  a_r2_high_word_pad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == 2'd1) |-> (reg_rdata_o[DATA_W-1:NUM_GRP-DATA_W] == '0));
endmodule

bind gpio_irq_summary gpio_irq_summary_chk #(
  .NUM_PINS(NUM_PINS), .GRP_SIZE(GRP_SIZE), .LEN_W(LEN_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .db_wr_i     (db_wr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .int_en_rd_o (int_en_rd_o),
  .host_irq_o  (host_irq_o),
  .quiet       (quiet),
  .en_q        (en_q),
  .len_q       (len_q),
  .sum_q       (sum_q)
);

// File: tb/gpio_irq_summary_bench.sv
module gpio_irq_summary_bench;
  localparam int NP = 184;
  localparam int NG = 46;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pend = '0;
  logic [NP-1:0] int_en = '0;
  logic          db_wr = 1'b0;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = 2'd0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] int_en_rd;
  logic          host_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_summary u_gpio_irq_summary (
    .clk_i(clk), .rst_ni(rst_n), .pend_i(pend), .int_en_i(int_en),
    .db_wr_i(db_wr), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .int_en_rd_o(int_en_rd), .host_irq_o(host_irq)
  );

  // reference model
  logic [63:0] m_sum;
  logic [11:0] m_len;
  logic        m_en;
  logic        m_irq;
  int          m_cnt;

  function automatic logic [63:0] grp_of(input logic [NP-1:0] p);
    logic [63:0] r = '0;
    for (int g = 0; g < NG; g++) r[g] = |p[g*4 +: 4];
    return r;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return m_sum[31:0];
      2'd1:    return m_sum[63:32];
      2'd2:    return {15'd0, m_en, 4'd0, m_len};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sum = '0; m_len = '0; m_en = 1'b0; m_irq = 1'b0; m_cnt = 0;
    end else begin
      logic blk, ctrl, eoi;
      blk  = (m_cnt != 0);
      ctrl = reg_wr && reg_addr == 2'd2;
      eoi  = ctrl && reg_wdata[31];
      if (eoi) m_irq = 1'b0;
      else if (m_sum != '0) m_irq = 1'b1;
      m_sum = blk ? '0 : grp_of(pend);
      if (db_wr && m_en) m_cnt = int'(m_len);
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      if (ctrl) begin
        m_len = reg_wdata[11:0];
        m_en  = reg_wdata[16];
      end
    end
  end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R4/R5 host line", NP'(host_irq), NP'(m_irq));
      chk(reg_addr == 2'd2 ? "R3 ctrl read" : "R1/R2 status read",
          NP'(reg_rdata), NP'(exp_rd(reg_addr)));
      chk("R7 enable readback", int_en_rd, (m_cnt != 0) ? '0 : int_en);
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reg_wr = 1'b0; db_wr = 1'b0;
    end
  endtask

  task automatic ctrl_write(input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = d; db_wr = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // counts samples with enable readback zero; strobes at cycles a and b
  task automatic win_count(input int a, input int b, input bit mw,
                           input logic [31:0] md, output int n);
    n = 0;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      int_en = '1;
      db_wr  = (i == a) || (i == b);
      reg_wr = mw && (i == 0);
      reg_addr = 2'd2; reg_wdata = md;
      #1;
      if (int_en_rd == '0) n++;
    end
    db_wr = 1'b0; reg_wr = 1'b0;
  endtask

  initial begin
    int n;
    void'($urandom(32'd7321));
    #9 rst_n = 1'b1;
    @(negedge clk); #1;
    reg_addr = 2'd2; #0.5;
    chk("R10 reset line", NP'(host_irq), '0);
    chk("R10 reset ctrl", NP'(reg_rdata), '0);

    ctrl_write(32'h0001_0003);
    win_count(0, -1, 1'b0, 32'h0, n);
    chk("R6 window length 3", NP'(n), NP'(3));
    idle(4);
    win_count(0, 2, 1'b0, 32'h0, n);
    chk("R8 restart window", NP'(n), NP'(5));
    idle(4);
    win_count(0, -1, 1'b1, 32'h0001_0008, n);
    chk("R9 old length used", NP'(n), NP'(3));
    idle(10);
    ctrl_write(32'h0001_0000);
    win_count(0, -1, 1'b0, 32'h0, n);
    chk("R6 zero length", NP'(n), NP'(0));
    ctrl_write(32'h0000_0005);
    win_count(0, -1, 1'b0, 32'h0, n);
    chk("R6 enable clear", NP'(n), NP'(0));

    // sticky line and eoi collision
    @(negedge clk); pend = '0; pend[183] = 1'b1; reg_addr = 2'd1;
    @(negedge clk); pend = '0; #1;
    chk("R2 top group high word", NP'(reg_rdata), NP'(32'h0000_2000));
    @(negedge clk); #1;
    chk("R4 line rises", NP'(host_irq), NP'(1));
    idle(3); #1;
    chk("R4 line sticky", NP'(host_irq), NP'(1));
    ctrl_write(32'h8000_0005); #1;
    chk("R5 eoi drops line", NP'(host_irq), NP'(0));
    idle(2); #1;
    chk("R5 stays low without pending", NP'(host_irq), NP'(0));
    pend[1] = 1'b1;
    idle(3);
    ctrl_write(32'h8000_0005); #1;
    chk("R5 eoi wins over summary", NP'(host_irq), NP'(0));
    @(negedge clk); #1;
    chk("R5 line re-rises", NP'(host_irq), NP'(1));
    pend = '0;

    // random traffic
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      pend = '0;
      if ($urandom_range(0, 2) == 0) pend[$urandom_range(0, NP-1)] = 1'b1;
      if ($urandom_range(0, 5) == 0) pend[$urandom_range(0, NP-1)] = 1'b1;
      for (int w = 0; w < NP; w += 32) int_en[w +: 8] = 8'($urandom);
      db_wr = ($urandom_range(0, 15) == 0);
      reg_addr = 2'($urandom);
      reg_wr = ($urandom_range(0, 9) == 0);
      reg_wdata = $urandom;
      if (reg_addr == 2'd2) begin
        reg_wdata[11:0] = 12'($urandom_range(0, 12));
        reg_wr = reg_wr || ($urandom_range(0, 9) == 0);
      end
    end
    idle(2);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule